// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block sequences traps for a small 32-bit in-order core whose branches have a delay slot. Each cycle it looks at the pending external and timer interrupt lines, a synchronous exception request with its 4-bit cause index, and a return-from-trap command. The core also supplies its current PC, its next PC, the pending branch target and a flag that marks the current instruction as a delay-slot instruction. The block owns the live status word, the saved status word and the saved trap PC. The core may also write the status word through a plain write port.

When a trap is taken, the block saves the status word and a trap PC. It then drops the translation and interrupt enables, enters supervisor mode and redirects fetch to a vector computed from the cause index. On a return command it restores the saved status and redirects both PC and next PC to the saved trap PC. It asks for a translation-cache flush on every entry. On a return it asks for a flush only when the privilege or translation mode actually changes. Each entry or return takes effect at the next clock edge, and every result is held in a register.

Top module: `trap_seq`

## Requirements
- R1: An external interrupt is taken, with cause code 8, only while `ext_irq_pend` is high and status bit 2 (interrupt enable) is set.
- R2: A timer interrupt is taken, with cause code 5, only while `tick_irq_pend` is high and status bit 1 (tick enable) is set. When both interrupts qualify in the same cycle, the timer interrupt is the one taken.
- R3: A synchronous exception request takes precedence over both interrupts. Any trap candidate takes precedence over a return command, and a return command takes precedence over a status write.
- R4: On entry, `saved_status` takes the whole previous status word. The new status has bits 1, 2, 5 (data translation) and 6 (instruction translation) cleared and bit 0 (supervisor) set. All other bits are unchanged.
- R5: Outside a delay slot, causes 5, 8, 12 (system call) and 13 (floating point) save `next_pc` as the trap PC, and every other cause saves `cur_pc`.
- R6: In a delay slot, the four causes listed in R5 save `branch_tgt`, and every other cause saves `cur_pc` minus 4. The entry also sets status bit 13 and pulses `dslot_clear`.
- R7: One cycle after a legal trap is requested, `redirect_valid` pulses. `redirect_pc` is then the cause index shifted left by 8, and `redirect_npc` is that value plus 4.
- R8: A trap whose cause index is 0 or 14 or higher pulses `cause_err` for one cycle. It leaves the status word, the saved status and the saved PC unchanged, and it raises neither a redirect nor a flush.
- R9: Every legal trap entry pulses `tlb_flush` together with `redirect_valid`.
- R10: A return command loads the status word from `saved_status` and redirects both PC and next PC to `saved_pc`.
- R11: A return pulses `tlb_flush` only when status bit 0, bit 5 or bit 6 differs between the live and the saved status.
- R12: `wake` is high in every cycle in which either interrupt line is pending, whatever the enables are.
- R13: Reset sets the status word to 0x0001 and clears the saved status and the saved PC. When no trap or return is accepted, `sr_wr_en` loads `sr_wr_data` into the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_pend | input | 1 | External interrupt pending |
| tick_irq_pend | input | 1 | Timer interrupt pending |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 4 | Cause index of the synchronous exception |
| rfe_req | input | 1 | Return-from-trap command |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 16 | Status word write value |
| cur_pc | input | 32 | PC of the current instruction |
| next_pc | input | 32 | PC of the next sequential instruction |
| branch_tgt | input | 32 | Target of the branch owning the delay slot |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| status | output | 16 | Live status word |
| saved_status | output | 16 | Status saved at trap entry |
| saved_pc | output | 32 | Trap PC saved at entry |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | New PC for the redirect |
| redirect_npc | output | 32 | New next PC for the redirect |
| dslot_clear | output | 1 | Pulse telling the core to drop its delay flag |
| tlb_flush | output | 1 | Pulse requesting a translation-cache flush |
| cause_err | output | 1 | Pulse on an illegal cause index |
| wake | output | 1 | An interrupt is pending |

## Verification
On every cycle, the assertions check the status bits forced on entry, the entry flush and vector alignment, the return that copies the saved status and PC, and the freeze of state with no redirect on an illegal cause. Only the bench's scenarios can show which PC is saved for each mix of delay slot and cause class, the arbitration order between the trap sources, and whether a return flushes for a given pair of live and saved modes. The bench's scenarios also cover the gating of each interrupt by its enable bit.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int CAUSE_W = 4;
    localparam int SR_W    = 16;

    // Status word bit positions
    localparam int SB_SUPV   = 0;
    localparam int SB_TICKEN = 1;
    localparam int SB_INTEN  = 2;
    localparam int SB_DMMU   = 5;
    localparam int SB_IMMU   = 6;
    localparam int SB_DSLOT  = 13;

    // Bits whose change on return calls for a translation flush
    localparam logic [SR_W-1:0] MODE_MASK =
        SR_W'((1 << SB_SUPV) | (1 << SB_DMMU) | (1 << SB_IMMU));

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_ENTER,
        ACT_RETURN,
        ACT_BADIDX,
        ACT_SRWR
    } act_e;

    typedef struct packed {
        act_e               act;
        logic [CAUSE_W-1:0] idx;
        logic               async_cls;
    } decision_t;

    function automatic logic [SR_W-1:0] entry_sr(input logic [SR_W-1:0] s,
                                                 input logic ds);
        logic [SR_W-1:0] n;
        n = s;
        n[SB_DMMU]   = 1'b0;
        n[SB_IMMU]   = 1'b0;
        n[SB_INTEN]  = 1'b0;
        n[SB_TICKEN] = 1'b0;
        n[SB_SUPV]   = 1'b1;
        if (ds) n[SB_DSLOT] = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CAUSE_TICK    = 4'd5,
    parameter logic [CAUSE_W-1:0] CAUSE_EXT     = 4'd8,
    parameter logic [CAUSE_W-1:0] CAUSE_SYSCALL = 4'd12,
    parameter logic [CAUSE_W-1:0] CAUSE_FPE     = 4'd13,
    parameter int unsigned        NUM_CAUSES    = 14
) (
    input  logic               ext_pend,
    input  logic               tick_pend,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               rfe_req,
    input  logic               sr_wr_en,
    input  logic               int_en,
    input  logic               tick_en,
    output decision_t          dec
);

    logic               hit;
    logic [CAUSE_W-1:0] idx;
    logic               legal;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (exc_req) begin
            hit = 1'b1;
            idx = exc_cause;
        end else if (tick_pend && tick_en) begin
            hit = 1'b1;
            idx = CAUSE_TICK;
        end else if (ext_pend && int_en) begin
            hit = 1'b1;
            idx = CAUSE_EXT;
        end
        legal = (idx != '0) && (32'(idx) < NUM_CAUSES);
    end

    always_comb begin
        dec.idx       = idx;
        dec.async_cls = (idx == CAUSE_TICK) || (idx == CAUSE_EXT) ||
                        (idx == CAUSE_SYSCALL) || (idx == CAUSE_FPE);
        if (hit)           dec.act = legal ? ACT_ENTER : ACT_BADIDX;
        else if (rfe_req)  dec.act = ACT_RETURN;
        else if (sr_wr_en) dec.act = ACT_SRWR;
        else               dec.act = ACT_IDLE;
    end

endmodule

// File: rtl/trap_pc_sel.sv
module trap_pc_sel
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int VEC_SHIFT  = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic               in_dslot,
    input  logic               async_cls,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    next_pc,
    input  logic [XLEN-1:0]    branch_tgt,
    input  logic [CAUSE_W-1:0] idx,
    output logic [XLEN-1:0]    epc_new,
    output logic [XLEN-1:0]    vec_pc
);

    always_comb begin
        unique case ({in_dslot, async_cls})
            2'b11:   epc_new = branch_tgt;
            2'b10:   epc_new = cur_pc - XLEN'(INSN_BYTES);
            2'b01:   epc_new = next_pc;
            default: epc_new = cur_pc;
        endcase
        vec_pc = XLEN'(idx) << VEC_SHIFT;
    end

endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              VEC_SHIFT  = 8,
    parameter int              INSN_BYTES = 4,
    parameter logic [SR_W-1:0] SR_RESET   = 16'h0001
) (
    input  logic            clk,
    input  logic            rst,
    input  act_e            act,
    input  logic            in_dslot,
    input  logic [SR_W-1:0] sr_wr_data,
    input  logic [XLEN-1:0] epc_new,
    input  logic [XLEN-1:0] vec_pc,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] esr_q,
    output logic [XLEN-1:0] epc_q,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic [XLEN-1:0] redir_npc,
    output logic            dslot_clr,
    output logic            tlb_flush,
    output logic            cause_err
);

    logic entering;
    logic returning;
    assign entering  = (act == ACT_ENTER);
    assign returning = (act == ACT_RETURN);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q        <= SR_RESET;
            esr_q       <= '0;
            epc_q       <= '0;
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            redir_npc   <= '0;
            dslot_clr   <= 1'b0;
            tlb_flush   <= 1'b0;
            cause_err   <= 1'b0;
        end else begin
            redir_valid <= 1'b0;
            dslot_clr   <= 1'b0;
            tlb_flush   <= 1'b0;
            cause_err   <= 1'b0;
            case (act)
                ACT_ENTER: begin
                    esr_q       <= sr_q;
                    sr_q        <= entry_sr(sr_q, in_dslot);
                    epc_q       <= epc_new;
                    redir_valid <= 1'b1;
                    redir_pc    <= vec_pc;
                    redir_npc   <= vec_pc + XLEN'(INSN_BYTES);
                    tlb_flush   <= 1'b1;
                    dslot_clr   <= in_dslot;
                end
                ACT_RETURN: begin
                    sr_q        <= esr_q;
                    redir_valid <= 1'b1;
                    redir_pc    <= epc_q;
                    redir_npc   <= epc_q;
                    tlb_flush   <= |((sr_q ^ esr_q) & MODE_MASK);
                end
                ACT_BADIDX: cause_err <= 1'b1;
                ACT_SRWR:   sr_q <= sr_wr_data;
                default: ;
            endcase
        end
    end

    assert_entry_mode_R4: assert property (@(posedge clk) disable iff (rst)
        $past(entering) |-> (sr_q[SB_SUPV] && !sr_q[SB_INTEN] && !sr_q[SB_TICKEN]
                             && !sr_q[SB_DMMU] && !sr_q[SB_IMMU]
                             && esr_q == $past(sr_q)));

    assert_entry_flush_R9: assert property (@(posedge clk) disable iff (rst)
        $past(entering) |-> (tlb_flush && redir_valid));

    assert_vec_align_R7: assert property (@(posedge clk) disable iff (rst)
        $past(entering) |-> (redir_pc[VEC_SHIFT-1:0] == '0 &&
                             redir_npc == redir_pc + XLEN'(INSN_BYTES)));

    assert_return_restore_R10: assert property (@(posedge clk) disable iff (rst)
        $past(returning) |-> (sr_q == $past(esr_q) && redir_pc == $past(epc_q)
                              && redir_npc == $past(epc_q)));

    assert_badidx_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        cause_err |-> (sr_q == $past(sr_q) && esr_q == $past(esr_q) &&
                       epc_q == $past(epc_q) && !redir_valid && !tlb_flush));

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({redir_valid, cause_err}));

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int                 XLEN          = 32,
    parameter int                 VEC_SHIFT     = 8,
    parameter int                 INSN_BYTES    = 4,
    parameter logic [CAUSE_W-1:0] CAUSE_TICK    = 4'd5,
    parameter logic [CAUSE_W-1:0] CAUSE_EXT     = 4'd8,
    parameter logic [CAUSE_W-1:0] CAUSE_SYSCALL = 4'd12,
    parameter logic [CAUSE_W-1:0] CAUSE_FPE     = 4'd13,
    parameter int unsigned        NUM_CAUSES    = 14,
    parameter logic [SR_W-1:0]    SR_RESET      = 16'h0001
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_irq_pend,
    input  logic               tick_irq_pend,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               rfe_req,
    input  logic               sr_wr_en,
    input  logic [SR_W-1:0]    sr_wr_data,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    next_pc,
    input  logic [XLEN-1:0]    branch_tgt,
    input  logic               in_dslot,
    output logic [SR_W-1:0]    status,
    output logic [SR_W-1:0]    saved_status,
    output logic [XLEN-1:0]    saved_pc,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    redirect_npc,
    output logic               dslot_clear,
    output logic               tlb_flush,
    output logic               cause_err,
    output logic               wake
);

    decision_t       dec;
    logic [XLEN-1:0] epc_new;
    logic [XLEN-1:0] vec_pc;

    assign wake = ext_irq_pend | tick_irq_pend;

    trap_arbiter #(
        .CAUSE_TICK(CAUSE_TICK), .CAUSE_EXT(CAUSE_EXT),
        .CAUSE_SYSCALL(CAUSE_SYSCALL), .CAUSE_FPE(CAUSE_FPE),
        .NUM_CAUSES(NUM_CAUSES)
    ) u_arb (
        .ext_pend (ext_irq_pend),
        .tick_pend(tick_irq_pend),
        .exc_req  (exc_req),
        .exc_cause(exc_cause),
        .rfe_req  (rfe_req),
        .sr_wr_en (sr_wr_en),
        .int_en   (status[SB_INTEN]),
        .tick_en  (status[SB_TICKEN]),
        .dec      (dec)
    );

    trap_pc_sel #(
        .XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .INSN_BYTES(INSN_BYTES)
    ) u_pcsel (
        .in_dslot  (in_dslot),
        .async_cls (dec.async_cls),
        .cur_pc    (cur_pc),
        .next_pc   (next_pc),
        .branch_tgt(branch_tgt),
        .idx       (dec.idx),
        .epc_new   (epc_new),
        .vec_pc    (vec_pc)
    );

    trap_regs #(
        .XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .INSN_BYTES(INSN_BYTES),
        .SR_RESET(SR_RESET)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .act        (dec.act),
        .in_dslot   (in_dslot),
        .sr_wr_data (sr_wr_data),
        .epc_new    (epc_new),
        .vec_pc     (vec_pc),
        .sr_q       (status),
        .esr_q      (saved_status),
        .epc_q      (saved_pc),
        .redir_valid(redirect_valid),
        .redir_pc   (redirect_pc),
        .redir_npc  (redirect_npc),
        .dslot_clr  (dslot_clear),
        .tlb_flush  (tlb_flush),
        .cause_err  (cause_err)
    );

endmodule

// File: tb/trap_seq_bench.sv
module trap_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_irq_pend = 1'b0, tick_irq_pend = 1'b0;
    logic        exc_req = 1'b0, rfe_req = 1'b0, sr_wr_en = 1'b0, in_dslot = 1'b0;
    logic [3:0]  exc_cause = '0;
    logic [15:0] sr_wr_data = '0;
    logic [31:0] cur_pc = '0, next_pc = '0, branch_tgt = '0;
    logic [15:0] status, saved_status;
    logic [31:0] saved_pc, redirect_pc, redirect_npc;
    logic        redirect_valid, dslot_clear, tlb_flush, cause_err, wake;

    always #2.5 clk = ~clk;

    trap_seq u_trap_seq (
        .clk(clk), .rst(rst), .ext_irq_pend(ext_irq_pend), .tick_irq_pend(tick_irq_pend),
        .exc_req(exc_req), .exc_cause(exc_cause), .rfe_req(rfe_req), .sr_wr_en(sr_wr_en),
        .sr_wr_data(sr_wr_data), .cur_pc(cur_pc), .next_pc(next_pc), .branch_tgt(branch_tgt),
        .in_dslot(in_dslot), .status(status), .saved_status(saved_status), .saved_pc(saved_pc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .redirect_npc(redirect_npc),
        .dslot_clear(dslot_clear), .tlb_flush(tlb_flush), .cause_err(cause_err), .wake(wake)
    );

    typedef struct {
        string       tag;
        logic [15:0] sr, esr;
        logic [31:0] epc, rpc, rnpc;
        logic        rv, dsc, flush, err, wk;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // bench reference state
    logic [15:0] m_sr  = 16'h0001;
    logic [15:0] m_esr = 16'h0000;
    logic [31:0] m_epc = 32'h0;

    task automatic step(input logic ext, input logic tick, input logic exc,
                        input logic [3:0] cause, input logic rfe, input logic wr,
                        input logic [15:0] wd, input logic [31:0] cur,
                        input logic [31:0] npc, input logic [31:0] tgt,
                        input logic ds, input string tag);
        exp_t e;
        logic hit;
        logic [3:0] idx;
        logic async_c;
        @(negedge clk);
        ext_irq_pend = ext; tick_irq_pend = tick; exc_req = exc; exc_cause = cause;
        rfe_req = rfe; sr_wr_en = wr; sr_wr_data = wd; cur_pc = cur; next_pc = npc;
        branch_tgt = tgt; in_dslot = ds;
        e.tag = tag; e.rv = 0; e.rpc = 0; e.rnpc = 0; e.dsc = 0; e.flush = 0; e.err = 0;
        e.wk = ext | tick;
        hit = 0; idx = 0;
        if (exc) begin hit = 1; idx = cause; end
        else if (tick && m_sr[1]) begin hit = 1; idx = 4'd5; end
        else if (ext && m_sr[2]) begin hit = 1; idx = 4'd8; end
        if (hit) begin
            if (idx == 0 || idx >= 14) e.err = 1;
            else begin
                async_c = (idx == 5) || (idx == 8) || (idx == 12) || (idx == 13);
                if (ds) m_epc = async_c ? tgt : cur - 32'd4;
                else    m_epc = async_c ? npc : cur;
                m_esr = m_sr;
                m_sr  = (m_sr & ~16'h0066) | 16'h0001 | (ds ? 16'h2000 : 16'h0);
                e.rv = 1; e.rpc = {28'h0, idx} << 8; e.rnpc = e.rpc + 32'd4;
                e.flush = 1; e.dsc = ds;
            end
        end else if (rfe) begin
            e.flush = |((m_sr ^ m_esr) & 16'h0061);
            m_sr = m_esr;
            e.rv = 1; e.rpc = m_epc; e.rnpc = m_epc;
        end else if (wr) begin
            m_sr = wd;
        end
        e.sr = m_sr; e.esr = m_esr; e.epc = m_epc;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 4'd0, 0, 0, 16'h0, 32'h0, 32'h0, 32'h0, 0, tag);
    endtask

    // monitor: compares each queued expectation one step after the edge
    initial begin
        exp_t e;
        bit bad;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                bad = (status !== e.sr) || (saved_status !== e.esr) || (saved_pc !== e.epc) ||
                      (redirect_valid !== e.rv) || (dslot_clear !== e.dsc) ||
                      (tlb_flush !== e.flush) || (cause_err !== e.err) || (wake !== e.wk) ||
                      (e.rv && (redirect_pc !== e.rpc || redirect_npc !== e.rnpc));
                if (bad) begin
                    fails++;
                    $display("FAIL %s: act sr=%h esr=%h epc=%h rv=%b pc=%h npc=%h dsc=%b fl=%b err=%b wk=%b | exp sr=%h esr=%h epc=%h rv=%b pc=%h npc=%h dsc=%b fl=%b err=%b wk=%b",
                             e.tag, status, saved_status, saved_pc, redirect_valid, redirect_pc,
                             redirect_npc, dslot_clear, tlb_flush, cause_err, wake,
                             e.sr, e.esr, e.epc, e.rv, e.rpc, e.rnpc, e.dsc, e.flush, e.err, e.wk);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (status !== 16'h0001 || saved_status !== 16'h0 || saved_pc !== 32'h0 ||
            redirect_valid !== 1'b0 || tlb_flush !== 1'b0 || cause_err !== 1'b0) begin
            fails++;
            $display("FAIL R13 reset: act sr=%h esr=%h epc=%h exp sr=0001 esr=0000 epc=0",
                     status, saved_status, saved_pc);
        end
        @(negedge clk); rst = 0;

        // R1/R12: external pending but enable clear -> no entry, wake high
        step(1, 0, 0, 0, 0, 0, 0, 32'h100, 32'h104, 32'h0, 0, "R1 R12 ext gated");
        // R2: timer pending, tick enable clear -> ignored
        step(0, 1, 0, 0, 0, 0, 0, 32'h100, 32'h104, 32'h0, 0, "R2 tick gated");
        // R13: status write enables everything
        step(0, 0, 0, 0, 0, 1, 16'h0067, 0, 0, 0, 0, "R13 sr write");
        // R1 R4 R5 R7 R9: external interrupt outside delay slot
        step(1, 0, 0, 0, 0, 0, 0, 32'h1000, 32'h1004, 32'h2000, 0, "R1 R4 R5 R7 R9 ext entry");
        // R10 R11: return with mode change -> flush
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R10 R11 rfe flush");
        // R2: both pending, timer wins
        step(1, 1, 0, 0, 0, 0, 0, 32'h3000, 32'h3004, 32'h0, 0, "R2 tick beats ext");
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R10 rfe after tick");
        // R3: sync exception beats tick and rfe; R5 non-async saves cur_pc
        step(0, 1, 1, 4'd3, 1, 0, 0, 32'h4440, 32'h4444, 32'h0, 0, "R3 R5 sync wins");
        step(0, 0, 0, 0, 1, 1, 16'hFFFF, 0, 0, 0, 0, "R3 rfe beats write");
        // R11: return with equal mode bits -> no flush
        step(0, 0, 0, 0, 0, 1, 16'h0001, 0, 0, 0, 0, "R13 sr write supv");
        step(0, 0, 1, 4'd9, 0, 0, 0, 32'h5000, 32'h5004, 32'h0, 0, "R5 sync entry");
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R11 rfe no flush");
        // R6: delay-slot syscall saves target; delay-slot other saves cur-4
        step(0, 0, 1, 4'd12, 0, 0, 0, 32'h6008, 32'h600C, 32'h7700, 1, "R6 ds syscall");
        step(0, 0, 1, 4'd3, 0, 0, 0, 32'h8008, 32'h800C, 32'h9900, 1, "R6 ds other");
        step(0, 0, 1, 4'd13, 0, 0, 0, 32'hA000, 32'hA004, 32'hB000, 0, "R5 fpe no ds");
        // R8: illegal indices
        step(0, 0, 1, 4'd0, 0, 0, 0, 32'hC000, 32'hC004, 32'h0, 0, "R8 idx zero");
        step(0, 0, 1, 4'd15, 1, 0, 0, 32'hC000, 32'hC004, 32'h0, 1, "R8 idx high");
        step(0, 0, 1, 4'd14, 0, 0, 0, 32'hC000, 32'hC004, 32'h0, 0, "R8 idx count");
        step(0, 0, 1, 4'd13, 0, 0, 0, 32'hD000, 32'hD004, 32'h0, 1, "R6 ds fpe top legal");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 wake tick only");
        idle("R7 idle after");
        idle("drain");
        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule